// File: doc/BRIEF.md
# Flag Offset Register Loader

This block sets up the two threshold values that a dual-clock FIFO's flag logic compares against: the almost-empty offset (X) and the almost-full offset (Y). It runs in the write-side clock domain. While reset is held, two dual-purpose select pins choose how the offsets are programmed. The choices are a fixed preset pair, two words taken from the write data bus, or a serial bit stream shifted in on those same two pins.

After reset the selected method runs to completion and the block raises `prog_done`. Until then both offset outputs read zero and no write reaches the FIFO. In parallel mode the two writes that carry the offsets are used up by the loader and are not forwarded. Once programming is done, the offsets stay frozen until the next reset, and the write strobe passes straight through.

Top module: `ofs_loader`

## Requirements
- R1: The method is taken from {sel1_sen_n, sel0_sdata} at the last rising clock edge with rst_n low: 2'b00 parallel, 2'b01 preset A, 2'b10 preset B, 2'b11 serial. Pin changes after release do not change the method.
- R2: While rst_n is low, and afterwards until programming completes, prog_done is 0 and ofs_x and ofs_y both read 0.
- R3: In a preset mode, the first rising edge after release sets ofs_x and ofs_y to the chosen preset (PRESET_A = 8 or PRESET_B = 16) and raises prog_done.
- R4: In parallel mode, the first edge with wr_en high after release loads X and the second loads Y. prog_done rises on the second.
- R5: In serial mode, each edge with sel1_sen_n low shifts in sel0_sdata, and edges with sel1_sen_n high are ignored. prog_done rises on the edge that takes bit number 2*log2(DEPTH), which is 18 at the default depth of 512.
- R6: The serial stream carries Y first, most significant bit first, then X. The last bit lands in the X least significant bit.
- R7: fifo_wr_en follows wr_en only while prog_done is 1. Writes before that, including the two loading writes, are not forwarded.
- R8: Once prog_done is 1, it stays 1 and ofs_x/ofs_y hold until the next reset, whatever the select pins and wr_en do.
- R9: In parallel mode, only wr_data[log2(DEPTH)-1:0] is used. Higher data bits have no effect on the offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Synchronous active-low reset; the method is captured while low |
| sel1_sen_n | input | 1 | Method select bit 1 during reset; active-low serial enable afterwards |
| sel0_sdata | input | 1 | Method select bit 0 during reset; serial data afterwards |
| wr_en | input | 1 | Enabled write strobe from the write port |
| wr_data | input | DATA_W | Write data bus |
| fifo_wr_en | output | 1 | Write strobe forwarded to the FIFO array |
| ofs_x | output | log2(DEPTH) | Almost-empty offset |
| ofs_y | output | log2(DEPTH) | Almost-full offset |
| prog_done | output | 1 | Offsets are programmed |

## Verification
The assertions assume that the select pins hold a known 0/1 value on the last reset edge, since the checker keeps its own copy of the method from that edge. They also assume that rst_n stays low for at least one full clock edge. The stimulus changes every input only on the falling clock edge, so the pins are settled at each rising edge. It holds the select pins steady for several edges before releasing reset. Every reset in the bench lasts three edges.

// File: rtl/ofs_pkg.sv
// Package: shared types for the flag offset loader.
// Assumes: the two select pins are decoded as {bit1, bit0}.
package ofs_pkg;

    typedef enum logic [1:0] {
        MODE_PARALLEL = 2'b00,
        MODE_PRESET_A = 2'b01,
        MODE_PRESET_B = 2'b10,
        MODE_SERIAL   = 2'b11
    } ofs_mode_e;

    // True for either of the fixed-value methods.
    function automatic logic is_preset(input ofs_mode_e m);
        return (m == MODE_PRESET_A) || (m == MODE_PRESET_B);
    endfunction

endpackage

// File: rtl/ofs_mode_latch.sv
// Module: captures the programming method from the dual-purpose pins.
// It samples the pins on every edge while reset is low and holds the last
// sample once reset is released.
// Assumes: reset lasts at least one clock edge.
module ofs_mode_latch
    import ofs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel1,
    input  logic      sel0,
    output ofs_mode_e mode
);

    // Track the pins during reset; freeze the method after release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= ofs_mode_e'({sel1, sel0});
        end
    end

endmodule

// File: rtl/ofs_preset_loader.sv
// Module: loads one of two fixed offset pairs on the first edge after reset.
// Assumes: PRESET_A and PRESET_B fit in W bits.
module ofs_preset_loader
    import ofs_pkg::*;
#(
    parameter int W        = 9,
    parameter int PRESET_A = 8,
    parameter int PRESET_B = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ofs_mode_e    mode,
    output logic [W-1:0] x,
    output logic [W-1:0] y,
    output logic         done
);

    localparam logic [W-1:0] VAL_A = W'(PRESET_A);
    localparam logic [W-1:0] VAL_B = W'(PRESET_B);

    logic [W-1:0] pick;

    // Choose the preset that matches the latched method.
    always_comb begin
        pick = (mode == MODE_PRESET_B) ? VAL_B : VAL_A;
    end

    // Load both offsets once, on the first running edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x    <= '0;
            y    <= '0;
            done <= 1'b0;
        end else if (!done && is_preset(mode)) begin
            x    <= pick;
            y    <= pick;
            done <= 1'b1;
        end
    end

endmodule

// File: rtl/ofs_parallel_loader.sv
// Module: takes X then Y from the first two enabled writes after reset.
// Only the low W data bits are used.
// Assumes: wr_en is a single-cycle-qualified write strobe.
module ofs_parallel_loader #(
    parameter int W      = 9,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [W-1:0]      x,
    output logic [W-1:0]      y,
    output logic              done
);

    logic second;

    // Step through the two loading writes: X first, then Y.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x      <= '0;
            y      <= '0;
            second <= 1'b0;
            done   <= 1'b0;
        end else if (enable && wr_en && !done) begin
            if (!second) begin
                x      <= wr_data[W-1:0];
                second <= 1'b1;
            end else begin
                y    <= wr_data[W-1:0];
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ofs_serial_loader.sv
// Module: shifts Y then X in, most significant bit first, through one
// 2*W-bit chain. It finishes after exactly 2*W enabled bits.
// Assumes: serial enable is active low and sampled on clk.
module ofs_serial_loader #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         sen_n,
    input  logic         sdata,
    output logic [W-1:0] x,
    output logic [W-1:0] y,
    output logic         done
);

    localparam int BITS  = 2 * W;
    localparam int CNT_W = $clog2(BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

    logic [BITS-1:0]  chain;
    logic [CNT_W-1:0] count;

    // Shift one bit per enabled edge; stop after the final bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            count <= '0;
            done  <= 1'b0;
        end else if (enable && !sen_n && !done) begin
            chain <= {chain[BITS-2:0], sdata};
            count <= count + 1'b1;
            if (count == LAST) begin
                done <= 1'b1;
            end
        end
    end

    // Split the chain: the upper half holds the earlier (Y) bits.
    always_comb begin
        y = chain[BITS-1:W];
        x = chain[W-1:0];
    end

endmodule

// File: rtl/ofs_loader.sv
// Module: top of the flag offset loader. It latches the method at reset,
// runs the matching loader, presents the offsets once programmed and
// blocks FIFO writes until then.
// Assumes: DEPTH is a power of two; the presets fit in log2(DEPTH) bits.
module ofs_loader
    import ofs_pkg::*;
#(
    parameter int DEPTH    = 512,
    parameter int DATA_W   = 36,
    parameter int PRESET_A = 8,
    parameter int PRESET_B = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel1_sen_n,
    input  logic                     sel0_sdata,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     fifo_wr_en,
    output logic [$clog2(DEPTH)-1:0] ofs_x,
    output logic [$clog2(DEPTH)-1:0] ofs_y,
    output logic                     prog_done
);

    localparam int OFS_W = $clog2(DEPTH);

    ofs_mode_e        mode;
    logic [OFS_W-1:0] pre_x, pre_y, par_x, par_y, ser_x, ser_y;
    logic             pre_done, par_done, ser_done;
    logic [OFS_W-1:0] sel_x, sel_y;
    logic             sel_done;

    ofs_mode_latch u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .sel1  (sel1_sen_n),
        .sel0  (sel0_sdata),
        .mode  (mode)
    );

    ofs_preset_loader #(
        .W        (OFS_W),
        .PRESET_A (PRESET_A),
        .PRESET_B (PRESET_B)
    ) u_preset (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .x     (pre_x),
        .y     (pre_y),
        .done  (pre_done)
    );

    ofs_parallel_loader #(
        .W      (OFS_W),
        .DATA_W (DATA_W)
    ) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (mode == MODE_PARALLEL),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .x       (par_x),
        .y       (par_y),
        .done    (par_done)
    );

    ofs_serial_loader #(
        .W (OFS_W)
    ) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (mode == MODE_SERIAL),
        .sen_n  (sel1_sen_n),
        .sdata  (sel0_sdata),
        .x      (ser_x),
        .y      (ser_y),
        .done   (ser_done)
    );

    // Route the active loader's results by method.
    always_comb begin
        unique case (mode)
            MODE_PARALLEL: begin
                sel_x = par_x; sel_y = par_y; sel_done = par_done;
            end
            MODE_SERIAL: begin
                sel_x = ser_x; sel_y = ser_y; sel_done = ser_done;
            end
            default: begin
                sel_x = pre_x; sel_y = pre_y; sel_done = pre_done;
            end
        endcase
    end

    // Present offsets only when complete; gate FIFO writes on completion.
    always_comb begin
        prog_done  = sel_done && rst_n;
        ofs_x      = prog_done ? sel_x : '0;
        ofs_y      = prog_done ? sel_y : '0;
        fifo_wr_en = wr_en && prog_done;
    end

endmodule

// File: rtl/ofs_loader_chk.sv
// Module: checker for ofs_loader. It keeps its own copy of the method
// captured during reset and checks completion and holding behaviour.
// Assumes: select pins hold known values on the last reset edge.
module ofs_loader_chk #(
    parameter int OFS_W    = 9,
    parameter int PRESET_A = 8,
    parameter int PRESET_B = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel1_sen_n,
    input logic             sel0_sdata,
    input logic             wr_en,
    input logic             fifo_wr_en,
    input logic [OFS_W-1:0] ofs_x,
    input logic [OFS_W-1:0] ofs_y,
    input logic             prog_done
);

    logic [1:0] ck_mode;
    logic       first;

    // Checker's own record of the method and of the first running edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_mode <= {sel1_sen_n, sel0_sdata};
            first   <= 1'b1;
        end else begin
            first   <= 1'b0;
        end
    end

    // R3
    preset_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first && ck_mode == 2'b01) |=> (prog_done && ofs_x == OFS_W'(PRESET_A) && ofs_y == OFS_W'(PRESET_A)));

    // R3
    preset_b_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first && ck_mode == 2'b10) |=> (prog_done && ofs_x == OFS_W'(PRESET_B) && ofs_y == OFS_W'(PRESET_B)));

    // R4
    par_done_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(prog_done) && ck_mode == 2'b00) |-> $past(wr_en));

    // R5
    ser_done_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(prog_done) && ck_mode == 2'b11) |-> $past(!sel1_sen_n));

    // R7
    no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_mode == 2'b00 && !prog_done && wr_en) |-> !fifo_wr_en);

    // R8
    offsets_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |=> (prog_done && $stable(ofs_x) && $stable(ofs_y)));

endmodule

bind ofs_loader ofs_loader_chk #(
    .OFS_W    (OFS_W),
    .PRESET_A (PRESET_A),
    .PRESET_B (PRESET_B)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel1_sen_n (sel1_sen_n),
    .sel0_sdata (sel0_sdata),
    .wr_en      (wr_en),
    .fifo_wr_en (fifo_wr_en),
    .ofs_x      (ofs_x),
    .ofs_y      (ofs_y),
    .prog_done  (prog_done)
);

// File: tb/tb_ofs_loader.sv
module tb_ofs_loader;

    localparam int W  = 9;
    localparam int DW = 36;
    localparam int NV = 8;

    // Vector table entry: {method[1:0], x[8:0], y[8:0]}.
    localparam logic [19:0] VEC [NV] = '{
        {2'b11, 9'h1A5, 9'h0F3},
        {2'b11, 9'h000, 9'h1FF},
        {2'b11, 9'h1FF, 9'h000},
        {2'b11, 9'h155, 9'h0AA},
        {2'b00, 9'h003, 9'h100},
        {2'b00, 9'h1FF, 9'h1FF},
        {2'b01, 9'd8,   9'd8},
        {2'b10, 9'd16,  9'd16}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel1_sen_n = 1'b1;
    logic          sel0_sdata = 1'b1;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          fifo_wr_en;
    logic [W-1:0]  ofs_x, ofs_y;
    logic          prog_done;

    int applied = 0;
    int miscompares = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ofs_loader dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel1_sen_n (sel1_sen_n),
        .sel0_sdata (sel0_sdata),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .fifo_wr_en (fifo_wr_en),
        .ofs_x      (ofs_x),
        .ofs_y      (ofs_y),
        .prog_done  (prog_done)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Hold reset for three edges with the method on the pins; check R2 there.
    task automatic apply_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        {sel1_sen_n, sel0_sdata} = m;
        repeat (3) @(negedge clk);
        chk("R2 reset done", 36'(prog_done), 36'd0);
        chk("R2 reset x", 36'(ofs_x), 36'd0);
        chk("R2 reset y", 36'(ofs_y), 36'd0);
        rst_n = 1'b1;
        if (m == 2'b11) sel1_sen_n = 1'b1;
    endtask

    // Shift bits[hi] down to bits[lo], with an idle, toggling gap every 4 bits.
    task automatic ser_bits(input logic [17:0] bits, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            @(negedge clk);
            sel1_sen_n = 1'b0; sel0_sdata = bits[i];
            if (i % 4 == 0) begin
                @(negedge clk);
                sel1_sen_n = 1'b1; sel0_sdata = ~bits[i];
            end
        end
        @(negedge clk);
        sel1_sen_n = 1'b1;
    endtask

    // Two loading writes with junk above the offset bits (R9).
    task automatic par_load(input logic [8:0] x, input logic [8:0] y);
        @(negedge clk);
        wr_en = 1'b1; wr_data = {27'h6DB6DB6, x};
        #1 chk("R7 load write 1 blocked", 36'(fifo_wr_en), 36'd0);
        @(negedge clk);
        wr_data = {27'h5A5A5A5, y};
        #1 chk("R7 load write 2 blocked", 36'(fifo_wr_en), 36'd0);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_done(input string tag, input logic [8:0] x, input logic [8:0] y);
        chk({tag, " done"}, 36'(prog_done), 36'd1);
        chk({tag, " x"}, 36'(ofs_x), 36'(x));
        chk({tag, " y"}, 36'(ofs_y), 36'(y));
        wr_en = 1'b1;
        #1 chk("R7 write forwarded", 36'(fifo_wr_en), 36'd1);
        wr_en = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        // Vector table: one loop over every method (R3 R4 R5 R6 R9).
        for (int v = 0; v < NV; v++) begin
            logic [1:0] m;
            logic [8:0] vx, vy;
            {m, vx, vy} = VEC[v];
            apply_reset(m);
            case (m)
                2'b11: ser_bits({vy, vx}, 17, 0);
                2'b00: par_load(vx, vy);
                default: @(negedge clk);
            endcase
            check_done(m == 2'b11 ? "R6 serial" : (m == 2'b00 ? "R4 R9 parallel" : "R3 preset"), vx, vy);
        end

        // R1: pins changed after release do not change the preset method.
        apply_reset(2'b01);
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            sel1_sen_n = 1'b0; sel0_sdata = i[0];
        end
        @(negedge clk);
        sel1_sen_n = 1'b1;
        chk("R1 method frozen x", 36'(ofs_x), 36'd8);
        chk("R1 method frozen y", 36'(ofs_y), 36'd8);

        // R5 R7 R2: serial mode ignores writes; partial stream shows nothing.
        apply_reset(2'b11);
        @(negedge clk);
        wr_en = 1'b1;
        #1 chk("R7 write before done", 36'(fifo_wr_en), 36'd0);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R5 writes ignored", 36'(prog_done), 36'd0);
        ser_bits({9'h123, 9'h0C5}, 17, 1);
        chk("R2 partial done", 36'(prog_done), 36'd0);
        chk("R2 partial x", 36'(ofs_x), 36'd0);
        chk("R2 partial y", 36'(ofs_y), 36'd0);
        ser_bits({9'h123, 9'h0C5}, 0, 0);
        check_done("R5 R6 final bit", 9'h0C5, 9'h123);
        // R8: extra bits after completion are ignored.
        ser_bits(18'h3FFFF, 17, 12);
        chk("R8 after extra x", 36'(ofs_x), 36'h0C5);
        chk("R8 after extra y", 36'(ofs_y), 36'h123);

        // R1: a new reset mid-stream picks a new method.
        apply_reset(2'b11);
        ser_bits(18'h2AAAA, 17, 8);
        apply_reset(2'b00);
        par_load(9'h07E, 9'h181);
        check_done("R1 R4 new method", 9'h07E, 9'h181);
        // R8: further writes do not reload the offsets.
        @(negedge clk);
        wr_en = 1'b1; wr_data = 36'h000000011;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 parallel hold x", 36'(ofs_x), 36'h07E);
        chk("R8 parallel hold y", 36'(ofs_y), 36'h181);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule